// File: doc/BRIEF.md
# Boot Configuration Image Loader

The loader starts by itself when reset is released and fetches a short configuration image from an external serial memory. It does not handle the memory's bus protocol. It sees the memory as a byte reader: it raises a request with an address, and the reader answers with one data byte and an acknowledge pulse. The first two bytes form a signature. If either one is wrong, the loader stops at once, flags that it has finished, and every configuration output keeps its built-in default.

When the signature matches, the loader walks the image in order up to the last option byte. It fills the audio and identification outputs from the image: option flags, initial recording volume and mute, volume limits, vendor and product identifiers, string lengths and boost and clock-adjust enables. A group of fields replaces its defaults only when its own flag is set in the option byte. Vendor and product identifiers need only the signature. The loader also works out where each stored string begins in the memory, so that later descriptor logic can fetch the characters directly.

Top module: `cfg_boot_loader`

## Requirements
- R1: After reset the loader requests address 0 and then each following address in turn. Only one request is outstanding at a time. `rd_req` stays high with `rd_addr` stable until `rd_ack`. While `rst_n` is low, `done` and `image_ok` are 0 and every output holds its default.
- R2: Byte 0 must equal 0x43 and byte 1 must equal 0x4D. On a mismatch no further address is requested, `done` rises with `image_ok` low, and every configuration output keeps its default.
- R3: When the signature matches, reads continue through address 0x12 and then stop. `done` and `image_ok` rise on the edge that accepts byte 0x12 and stay high until reset.
- R4: Byte 0x02 appears on `opt_flags`, default 0x00. Bit 0 marks the manufacturer string valid, bit 1 the product string, bit 2 the serial string, bit 3 the memory string, bit 4 the initial recording settings, bit 5 the volume range, bit 6 selector disable and bit 7 remote wake enable.
- R5: When `opt_flags` bit 4 is set, byte 0x03 bits [5:0] set `init_vol_lo`, bit 6 sets `init_mute` and bit 7 sets `line_in_sel`. In the same case byte 0x04 bits [3:0] set `init_vol_hi`, bit 4 sets `hpf_by_rom` and bit 5 sets `hpf_on`. When bit 4 is clear, all six keep their defaults.
- R6: When `opt_flags` bit 5 is set, bytes 0x05 (low) and 0x06 (high) form `vol_max`, and bytes 0x07 (low) and 0x08 (high) form `vol_min`. When bit 5 is clear, both keep their defaults.
- R7: With a valid signature, bytes 0x0E and 0x0F (low first) replace `vendor_id`, and bytes 0x10 and 0x11 (low first) replace `product_id`. No option flag is needed.
- R8: `mfr_len`, `prod_len` and `ser_len` take bytes 0x0B, 0x0C and 0x0D only when `opt_flags` bit 0, 1 or 2 respectively is set. Otherwise each reads 0.
- R9: `mfr_base` is 0x50, `prod_base` is 0x50 + `mfr_len`, and `ser_base` is 0x50 + `mfr_len` + `prod_len`. All three are computed without wrapping at STR_AW bits.
- R10: Byte 0x12 bit 0 sets `boost_en` and bit 1 sets `pll_adj_en`, both 0 by default. Bytes 0x09 and 0x0A and bits [7:2] of byte 0x12 affect no output.
- R11: Once `done` is high, no request is issued and no output changes until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset, restarts the load |
| rd_req | output | 1 | Byte read request to the memory reader |
| rd_addr | output | EE_AW | Address of the requested byte |
| rd_ack | input | 1 | One-cycle pulse, `rd_data` valid |
| rd_data | input | 8 | Byte returned by the reader |
| done | output | 1 | Load finished, pass or fail |
| image_ok | output | 1 | Signature matched and image applied |
| opt_flags | output | 8 | Option flag byte |
| init_vol_lo | output | 6 | Initial volume low code |
| init_mute | output | 1 | Initial recording mute |
| line_in_sel | output | 1 | 1 line input, 0 microphone input |
| init_vol_hi | output | 4 | Initial volume high code |
| hpf_by_rom | output | 1 | High-pass filter controlled by image |
| hpf_on | output | 1 | High-pass filter enable |
| vol_max | output | 16 | Upper volume limit |
| vol_min | output | 16 | Lower volume limit |
| vendor_id | output | 16 | Vendor identifier |
| product_id | output | 16 | Product identifier |
| mfr_len | output | 8 | Manufacturer string length in characters |
| prod_len | output | 8 | Product string length in characters |
| ser_len | output | 8 | Serial string length in characters |
| mfr_base | output | STR_AW | Start address of manufacturer string |
| prod_base | output | STR_AW | Start address of product string |
| ser_base | output | STR_AW | Start address of serial string |
| boost_en | output | 1 | 18 dB boost enable |
| pll_adj_en | output | 1 | Clock adjustment enable |

## Verification
A wrong address counter or state shows on `rd_addr` the very next time the loader requests a byte, as a skipped or repeated address, or as a request issued after `done`. A wrongly latched option byte can stay hidden until later bytes arrive. It then shows after `done` as a field group that took image data when it should have kept its default, or the reverse, and as string start addresses that do not match the lengths. Sweeping every option byte value exposes each gating error within one load of about 40 to 80 cycles.

// File: rtl/cbl_pkg.sv
package cbl_pkg;

  localparam int STR_N = 3;

  localparam logic [7:0] SIG_B0 = 8'h43;
  localparam logic [7:0] SIG_B1 = 8'h4D;

  localparam logic [7:0] A_OPT    = 8'h02;
  localparam logic [7:0] A_ADC_L  = 8'h03;
  localparam logic [7:0] A_ADC_H  = 8'h04;
  localparam logic [7:0] A_MAX_L  = 8'h05;
  localparam logic [7:0] A_MAX_H  = 8'h06;
  localparam logic [7:0] A_MIN_L  = 8'h07;
  localparam logic [7:0] A_MIN_H  = 8'h08;
  localparam logic [7:0] A_LEN_0  = 8'h0B;
  localparam logic [7:0] A_VID_L  = 8'h0E;
  localparam logic [7:0] A_VID_H  = 8'h0F;
  localparam logic [7:0] A_PID_L  = 8'h10;
  localparam logic [7:0] A_PID_H  = 8'h11;
  localparam logic [7:0] A_MISC   = 8'h12;
  localparam logic [7:0] A_LAST   = A_MISC;

  localparam int OPT_ADC   = 4;
  localparam int OPT_RANGE = 5;

  typedef enum logic [1:0] {ST_REQ, ST_GAP, ST_DONE} seq_state_t;

  typedef logic [STR_N-1:0][7:0] len_vec_t;

  // signature byte expected at a given position (0 or 1)
  function automatic logic sig_match(input logic pos, input logic [7:0] data);
    return pos ? (data == SIG_B1) : (data == SIG_B0);
  endfunction

  // replace one byte lane of a 16-bit word
  function automatic logic [15:0] put_byte(input logic [15:0] word,
                                           input logic hi,
                                           input logic [7:0] b);
    return hi ? {b, word[7:0]} : {word[15:8], b};
  endfunction

  // start of the string stored after one of a given length
  function automatic logic [15:0] str_next(input logic [15:0] base,
                                           input logic [7:0] len);
    return base + {8'h00, len};
  endfunction

endpackage

// File: rtl/cbl_seq.sv
module cbl_seq
  import cbl_pkg::*;
#(
  parameter int EE_AW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             rd_req,
  output logic [EE_AW-1:0] rd_addr,
  input  logic             rd_ack,
  input  logic [7:0]       rd_data,
  output logic             byte_vld,
  output logic [EE_AW-1:0] byte_addr,
  output logic [7:0]       byte_data,
  output logic             sig_fail,
  output logic             load_end,
  output logic             done,
  output logic             image_ok
);

  seq_state_t       state_q;
  logic [EE_AW-1:0] addr_q;
  logic             in_sig;

  always_comb begin
    rd_req    = (state_q == ST_REQ);
    rd_addr   = addr_q;
    byte_vld  = rd_req && rd_ack;
    byte_addr = addr_q;
    byte_data = rd_data;
    in_sig    = (addr_q < EE_AW'(2));
    sig_fail  = byte_vld && in_sig && !sig_match(addr_q[0], rd_data);
    load_end  = byte_vld && !sig_fail && (addr_q == EE_AW'(A_LAST));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_REQ;
      addr_q   <= '0;
      done     <= 1'b0;
      image_ok <= 1'b0;
    end else begin
      unique case (state_q)
        ST_REQ: begin
          if (sig_fail) begin
            state_q <= ST_DONE;
            done    <= 1'b1;
          end else if (load_end) begin
            state_q  <= ST_DONE;
            done     <= 1'b1;
            image_ok <= 1'b1;
          end else if (byte_vld) begin
            state_q <= ST_GAP;
            addr_q  <= addr_q + EE_AW'(1);
          end
        end
        ST_GAP:  state_q <= ST_REQ;
        default: state_q <= ST_DONE;
      endcase
    end
  end

  p_req_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_ack |=> rd_req && $stable(rd_addr));

  p_addr_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld && !sig_fail && !load_end |=> rd_addr == $past(rd_addr) + EE_AW'(1));

  p_fail_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sig_fail |=> done && !image_ok);

  p_done_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done && $stable(image_ok));

  p_ok_needs_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    image_ok |-> done);

  p_quiet_after_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !rd_req);

endmodule

// File: rtl/cbl_capture.sv
module cbl_capture
  import cbl_pkg::*;
#(
  parameter int          EE_AW       = 8,
  parameter logic [5:0]  DEF_VOL_LO  = 6'h1E,
  parameter logic [3:0]  DEF_VOL_HI  = 4'h0,
  parameter logic [15:0] DEF_VOL_MAX = 16'h1E00,
  parameter logic [15:0] DEF_VOL_MIN = 16'hF000,
  parameter logic [15:0] DEF_VID     = 16'h2A3C,
  parameter logic [15:0] DEF_PID     = 16'h0107
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_vld,
  input  logic [EE_AW-1:0] byte_addr,
  input  logic [7:0]       byte_data,
  input  logic             done,
  output logic [7:0]       opt_flags,
  output logic [5:0]       init_vol_lo,
  output logic             init_mute,
  output logic             line_in_sel,
  output logic [3:0]       init_vol_hi,
  output logic             hpf_by_rom,
  output logic             hpf_on,
  output logic [15:0]      vol_max,
  output logic [15:0]      vol_min,
  output logic [15:0]      vendor_id,
  output logic [15:0]      product_id,
  output len_vec_t         str_len,
  output logic             boost_en,
  output logic             pll_adj_en
);

  logic wr_opt, wr_adc_l, wr_adc_h, wr_max_l, wr_max_h, wr_min_l, wr_min_h;
  logic wr_vid_l, wr_vid_h, wr_pid_l, wr_pid_h, wr_misc;
  logic adc_open, range_open;

  always_comb begin
    adc_open   = opt_flags[OPT_ADC];
    range_open = opt_flags[OPT_RANGE];
    wr_opt   = byte_vld && (byte_addr == EE_AW'(A_OPT));
    wr_adc_l = byte_vld && (byte_addr == EE_AW'(A_ADC_L)) && adc_open;
    wr_adc_h = byte_vld && (byte_addr == EE_AW'(A_ADC_H)) && adc_open;
    wr_max_l = byte_vld && (byte_addr == EE_AW'(A_MAX_L)) && range_open;
    wr_max_h = byte_vld && (byte_addr == EE_AW'(A_MAX_H)) && range_open;
    wr_min_l = byte_vld && (byte_addr == EE_AW'(A_MIN_L)) && range_open;
    wr_min_h = byte_vld && (byte_addr == EE_AW'(A_MIN_H)) && range_open;
    wr_vid_l = byte_vld && (byte_addr == EE_AW'(A_VID_L));
    wr_vid_h = byte_vld && (byte_addr == EE_AW'(A_VID_H));
    wr_pid_l = byte_vld && (byte_addr == EE_AW'(A_PID_L));
    wr_pid_h = byte_vld && (byte_addr == EE_AW'(A_PID_H));
    wr_misc  = byte_vld && (byte_addr == EE_AW'(A_MISC));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      opt_flags <= 8'h00;
    end else if (wr_opt) begin
      opt_flags <= byte_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      init_vol_lo <= DEF_VOL_LO;
      init_mute   <= 1'b0;
      line_in_sel <= 1'b0;
      init_vol_hi <= DEF_VOL_HI;
      hpf_by_rom  <= 1'b0;
      hpf_on      <= 1'b0;
    end else begin
      if (wr_adc_l) begin
        init_vol_lo <= byte_data[5:0];
        init_mute   <= byte_data[6];
        line_in_sel <= byte_data[7];
      end
      if (wr_adc_h) begin
        init_vol_hi <= byte_data[3:0];
        hpf_by_rom  <= byte_data[4];
        hpf_on      <= byte_data[5];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vol_max <= DEF_VOL_MAX;
      vol_min <= DEF_VOL_MIN;
    end else begin
      if (wr_max_l || wr_max_h) vol_max <= put_byte(vol_max, wr_max_h, byte_data);
      if (wr_min_l || wr_min_h) vol_min <= put_byte(vol_min, wr_min_h, byte_data);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vendor_id  <= DEF_VID;
      product_id <= DEF_PID;
    end else begin
      if (wr_vid_l || wr_vid_h) vendor_id  <= put_byte(vendor_id, wr_vid_h, byte_data);
      if (wr_pid_l || wr_pid_h) product_id <= put_byte(product_id, wr_pid_h, byte_data);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      boost_en   <= 1'b0;
      pll_adj_en <= 1'b0;
    end else if (wr_misc) begin
      boost_en   <= byte_data[0];
      pll_adj_en <= byte_data[1];
    end
  end

  // one length register per stored string, each gated by its own flag bit
  for (genvar gi = 0; gi < STR_N; gi++) begin : g_len
    logic wr_len;
    assign wr_len = byte_vld && opt_flags[gi] &&
                    (byte_addr == EE_AW'(A_LEN_0) + EE_AW'(gi));

    always_ff @(posedge clk) begin
      if (!rst_n)      str_len[gi] <= 8'h00;
      else if (wr_len) str_len[gi] <= byte_data;
    end

    p_len_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !opt_flags[gi] |-> str_len[gi] == 8'h00);
  end

  p_adc_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld && byte_addr == EE_AW'(A_ADC_L) && !opt_flags[OPT_ADC]
    |=> $stable({init_vol_lo, init_mute, line_in_sel}));

  p_range_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld && (byte_addr == EE_AW'(A_MAX_L) || byte_addr == EE_AW'(A_MIN_H))
    && !opt_flags[OPT_RANGE] |=> $stable(vol_max) && $stable(vol_min));

  p_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> $stable({opt_flags, vendor_id, product_id, vol_max, vol_min, str_len}));

endmodule

// File: rtl/cbl_strmap.sv
module cbl_strmap
  import cbl_pkg::*;
#(
  parameter int STR_AW   = 10,
  parameter int STR_BASE = 'h50
) (
  input  len_vec_t                      str_len,
  output logic [STR_N-1:0][STR_AW-1:0] str_base
);

  logic [15:0] acc;

  always_comb begin
    acc = 16'(STR_BASE);
    for (int i = 0; i < STR_N; i++) begin
      str_base[i] = STR_AW'(acc);
      acc = str_next(acc, str_len[i]);
    end
  end

  always_comb begin
    for (int i = 1; i < STR_N; i++) begin
      p_base_order_r9: assert (str_base[i] >= str_base[i-1]);
    end
  end

endmodule

// File: rtl/cfg_boot_loader.sv
module cfg_boot_loader
  import cbl_pkg::*;
#(
  parameter int          EE_AW       = 8,
  parameter int          STR_AW      = 10,
  parameter int          STR_BASE    = 'h50,
  parameter logic [5:0]  DEF_VOL_LO  = 6'h1E,
  parameter logic [3:0]  DEF_VOL_HI  = 4'h0,
  parameter logic [15:0] DEF_VOL_MAX = 16'h1E00,
  parameter logic [15:0] DEF_VOL_MIN = 16'hF000,
  parameter logic [15:0] DEF_VID     = 16'h2A3C,
  parameter logic [15:0] DEF_PID     = 16'h0107
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              rd_req,
  output logic [EE_AW-1:0]  rd_addr,
  input  logic              rd_ack,
  input  logic [7:0]        rd_data,
  output logic              done,
  output logic              image_ok,
  output logic [7:0]        opt_flags,
  output logic [5:0]        init_vol_lo,
  output logic              init_mute,
  output logic              line_in_sel,
  output logic [3:0]        init_vol_hi,
  output logic              hpf_by_rom,
  output logic              hpf_on,
  output logic [15:0]       vol_max,
  output logic [15:0]       vol_min,
  output logic [15:0]       vendor_id,
  output logic [15:0]       product_id,
  output logic [7:0]        mfr_len,
  output logic [7:0]        prod_len,
  output logic [7:0]        ser_len,
  output logic [STR_AW-1:0] mfr_base,
  output logic [STR_AW-1:0] prod_base,
  output logic [STR_AW-1:0] ser_base,
  output logic              boost_en,
  output logic              pll_adj_en
);

  logic             byte_vld;
  logic [EE_AW-1:0] byte_addr;
  logic [7:0]       byte_data;
  logic             sig_fail;
  logic             load_end;
  len_vec_t         str_len;
  logic [STR_N-1:0][STR_AW-1:0] str_base;

  cbl_seq #(.EE_AW(EE_AW)) i_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_req    (rd_req),
    .rd_addr   (rd_addr),
    .rd_ack    (rd_ack),
    .rd_data   (rd_data),
    .byte_vld  (byte_vld),
    .byte_addr (byte_addr),
    .byte_data (byte_data),
    .sig_fail  (sig_fail),
    .load_end  (load_end),
    .done      (done),
    .image_ok  (image_ok)
  );

  cbl_capture #(
    .EE_AW       (EE_AW),
    .DEF_VOL_LO  (DEF_VOL_LO),
    .DEF_VOL_HI  (DEF_VOL_HI),
    .DEF_VOL_MAX (DEF_VOL_MAX),
    .DEF_VOL_MIN (DEF_VOL_MIN),
    .DEF_VID     (DEF_VID),
    .DEF_PID     (DEF_PID)
  ) i_capture (
    .clk         (clk),
    .rst_n       (rst_n),
    .byte_vld    (byte_vld),
    .byte_addr   (byte_addr),
    .byte_data   (byte_data),
    .done        (done),
    .opt_flags   (opt_flags),
    .init_vol_lo (init_vol_lo),
    .init_mute   (init_mute),
    .line_in_sel (line_in_sel),
    .init_vol_hi (init_vol_hi),
    .hpf_by_rom  (hpf_by_rom),
    .hpf_on      (hpf_on),
    .vol_max     (vol_max),
    .vol_min     (vol_min),
    .vendor_id   (vendor_id),
    .product_id  (product_id),
    .str_len     (str_len),
    .boost_en    (boost_en),
    .pll_adj_en  (pll_adj_en)
  );

  cbl_strmap #(.STR_AW(STR_AW), .STR_BASE(STR_BASE)) i_strmap (
    .str_len  (str_len),
    .str_base (str_base)
  );

  assign mfr_len   = str_len[0];
  assign prod_len  = str_len[1];
  assign ser_len   = str_len[2];
  assign mfr_base  = str_base[0];
  assign prod_base = str_base[1];
  assign ser_base  = str_base[2];

  p_fail_keeps_ids_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done && !image_ok |-> vendor_id == DEF_VID && product_id == DEF_PID
                          && opt_flags == 8'h00);

  p_end_sets_ok_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load_end |=> image_ok);

  p_misc_at_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
    load_end |=> boost_en == $past(byte_data[0]) && pll_adj_en == $past(byte_data[1]));

endmodule

// File: tb/test_cfg_boot_loader.sv
`timescale 1ns/1ps
module test_cfg_boot_loader;

  localparam logic [5:0]  D_VLO  = 6'h1E;
  localparam logic [3:0]  D_VHI  = 4'h0;
  localparam logic [15:0] D_VMAX = 16'h1E00;
  localparam logic [15:0] D_VMIN = 16'hF000;
  localparam logic [15:0] D_VID  = 16'h2A3C;
  localparam logic [15:0] D_PID  = 16'h0107;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        rd_req, rd_ack = 1'b0;
  logic [7:0]  rd_addr, rd_data = 8'h00;
  logic        done, image_ok, init_mute, line_in_sel, hpf_by_rom, hpf_on;
  logic        boost_en, pll_adj_en;
  logic [7:0]  opt_flags, mfr_len, prod_len, ser_len;
  logic [5:0]  init_vol_lo;
  logic [3:0]  init_vol_hi;
  logic [15:0] vol_max, vol_min, vendor_id, product_id;
  logic [9:0]  mfr_base, prod_base, ser_base;

  logic [7:0] mem [0:31];
  int n_checks = 0, n_err = 0, n_reads = 0, lat_cfg = 0, wcnt = 0;

  cfg_boot_loader i_cfg_boot_loader (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_ack(rd_ack), .rd_data(rd_data), .done(done), .image_ok(image_ok),
    .opt_flags(opt_flags), .init_vol_lo(init_vol_lo), .init_mute(init_mute),
    .line_in_sel(line_in_sel), .init_vol_hi(init_vol_hi),
    .hpf_by_rom(hpf_by_rom), .hpf_on(hpf_on), .vol_max(vol_max),
    .vol_min(vol_min), .vendor_id(vendor_id), .product_id(product_id),
    .mfr_len(mfr_len), .prod_len(prod_len), .ser_len(ser_len),
    .mfr_base(mfr_base), .prod_base(prod_base), .ser_base(ser_base),
    .boost_en(boost_en), .pll_adj_en(pll_adj_en)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // byte reader model: answers after lat_cfg extra cycles, checks address order
  initial begin
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        rd_ack = 1'b0;
        wcnt = 0;
      end else if (rd_ack) begin
        rd_ack = 1'b0;
      end else if (rd_req) begin
        if (wcnt < lat_cfg) wcnt++;
        else begin
          wcnt = 0;
          chk("R1 address order", 32'(rd_addr), 32'(n_reads));
          rd_data = mem[rd_addr[4:0]];
          rd_ack = 1'b1;
          n_reads++;
        end
      end
    end
  end

  task automatic run_check();
    logic sig_ok;
    int exp_reads;
    logic [7:0] o;
    logic [7:0] lm, lp, ls;
    int reads_at_done;
    logic [15:0] vid_at;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 reset done", 32'(done), 0);
    chk("R1 reset image_ok", 32'(image_ok), 0);
    chk("R1 reset vid", 32'(vendor_id), 32'(D_VID));
    chk("R1 reset addr", 32'(rd_addr), 0);
    n_reads = 0;
    rst_n = 1'b1;
    for (int k = 0; k < 600 && !done; k++) @(negedge clk);

    sig_ok = (mem[0] == 8'h43) && (mem[1] == 8'h4D);
    exp_reads = (mem[0] != 8'h43) ? 1 : (mem[1] != 8'h4D) ? 2 : 19;
    o = sig_ok ? mem[2] : 8'h00;

    chk("R3 done", 32'(done), 1);
    chk(sig_ok ? "R3 image_ok" : "R2 image_ok", 32'(image_ok), 32'(sig_ok));
    chk(sig_ok ? "R3 read count" : "R2 read count", 32'(n_reads), 32'(exp_reads));
    chk("R4 opt_flags", 32'(opt_flags), 32'(o));
    chk("R5 vol_lo", 32'(init_vol_lo), 32'(o[4] ? mem[3][5:0] : D_VLO));
    chk("R5 mute", 32'(init_mute), 32'(o[4] ? mem[3][6] : 1'b0));
    chk("R5 line_in", 32'(line_in_sel), 32'(o[4] ? mem[3][7] : 1'b0));
    chk("R5 vol_hi", 32'(init_vol_hi), 32'(o[4] ? mem[4][3:0] : D_VHI));
    chk("R5 hpf ctrl", 32'(hpf_by_rom), 32'(o[4] ? mem[4][4] : 1'b0));
    chk("R5 hpf on", 32'(hpf_on), 32'(o[4] ? mem[4][5] : 1'b0));
    chk("R6 vol_max", 32'(vol_max), 32'(o[5] ? {mem[6], mem[5]} : D_VMAX));
    chk("R6 vol_min", 32'(vol_min), 32'(o[5] ? {mem[8], mem[7]} : D_VMIN));
    chk(sig_ok ? "R7 vendor" : "R2 vendor", 32'(vendor_id), 32'(sig_ok ? {mem[15], mem[14]} : D_VID));
    chk(sig_ok ? "R7 product" : "R2 product", 32'(product_id), 32'(sig_ok ? {mem[17], mem[16]} : D_PID));
    lm = o[0] ? mem[11] : 8'h00;
    lp = o[1] ? mem[12] : 8'h00;
    ls = o[2] ? mem[13] : 8'h00;
    chk("R8 mfr_len", 32'(mfr_len), 32'(lm));
    chk("R8 prod_len", 32'(prod_len), 32'(lp));
    chk("R8 ser_len", 32'(ser_len), 32'(ls));
    chk("R9 mfr_base", 32'(mfr_base), 32'h50);
    chk("R9 prod_base", 32'(prod_base), 32'h50 + 32'(lm));
    chk("R9 ser_base", 32'(ser_base), 32'h50 + 32'(lm) + 32'(lp));
    chk("R10 boost", 32'(boost_en), 32'(sig_ok ? mem[18][0] : 1'b0));
    chk("R10 pll", 32'(pll_adj_en), 32'(sig_ok ? mem[18][1] : 1'b0));

    reads_at_done = n_reads;
    vid_at = vendor_id;
    repeat (8) @(negedge clk);
    chk("R11 no reads after done", 32'(n_reads), 32'(reads_at_done));
    chk("R11 vid frozen", 32'(vendor_id), 32'(vid_at));
    chk("R11 done held", 32'(done), 1);
  endtask

  task automatic fill(input int seed);
    for (int i = 0; i < 32; i++) mem[i] = 8'((seed * 7 + i * 13) ^ 8'h5A);
    mem[0] = 8'h43;
    mem[1] = 8'h4D;
  endtask

  initial begin
    // R2 first signature byte wrong
    fill(3); mem[0] = 8'h44; lat_cfg = 0; run_check();
    // R2 second signature byte wrong
    fill(5); mem[1] = 8'h4C; lat_cfg = 1; run_check();
    // R9 longest strings, all groups enabled, R10 reserved bytes set
    fill(9); mem[2] = 8'hFF; mem[11] = 8'hFF; mem[12] = 8'hFF; mem[13] = 8'hFF;
    mem[9] = 8'hFF; mem[10] = 8'hFF; mem[18] = 8'hFC; lat_cfg = 2; run_check();
    // sweep every option byte value
    for (int opt = 0; opt < 256; opt++) begin
      fill(opt);
      mem[2] = 8'(opt);
      lat_cfg = opt % 3;
      run_check();
    end
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL R3 watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

endmodule